// File: doc/BRIEF.md
# Non-volatile write commit controller

This block sits between a two-wire serial front end and the non-volatile storage behind it. It follows each write transaction the front end reports: the start of the transaction, the target space (main array or register bank), each data byte that was received and acknowledged, and the stop event. When the stop arrives, the block decides whether the transaction is committed. If it is, the block pulses a commit strobe to the storage and holds a busy flag for a fixed number of cycles. The front end uses the busy flag to stop responding to the bus, so a host can find out when the commit is over by repeatedly sending an address and waiting for an acknowledge.

Several conditions prevent a commit. A transaction that is cut short is dropped. A write that touches a configurable protected window of the array is acknowledged by the front end but discarded. Register-bank writes are refused until a two-step unlock sequence has been written to the status register. The time-keeping section of the register bank accepts only a full eight-byte page. The page buffer and the memory itself are outside this block.

Top module: `nv_commit_ctrl`

## Requirements
- R1: After reset, `busy`, `commit_pulse` and `reg_unlocked` are all 0.
- R2: Consider a transaction that starts with `txn_start`, takes at least one `byte_ack`, and then receives `stop_evt` while `mid_byte` is 0. If it is eligible, `commit_pulse` is 1 for exactly one cycle, in the cycle after the edge that samples the stop. In that same cycle `commit_space` equals the transaction's `txn_space` (0 = array, 1 = register bank).
- R3: A stop that arrives with no acknowledged data byte, or with `mid_byte` at 1, aborts the transaction. No commit follows, and the unlock state is left unchanged.
- R4: An array write is discarded if any byte address lies in [`prot_base`, `prot_base`+`prot_size`). No commit pulse and no busy window follow it.
- R5: Each commit raises `busy` in the same cycle as `commit_pulse`, and `busy` stays high for exactly COMMIT_CYCLES cycles.
- R6: While `busy` is 1, every input event is ignored. A complete write sent during that time produces no commit, and `reg_unlocked` does not change.
- R7: The status register is register-bank address STATUS_ADDR (default 3Fh). It is written with one-byte operations that never commit. A clean one-byte status write of 02h, followed directly by a clean one-byte status write of 06h, sets `reg_unlocked` to 1.
- R8: `reg_unlocked` returns to 0 in three cases: a status write with any other value, a multi-byte write that includes the status register, or any other clean write placed between the 02h and the 06h.
- R9: A register-bank write that touches neither the status register nor the time-keeping section commits only while `reg_unlocked` is 1.
- R10: The time-keeping section covers RTC_LEN (8) registers starting at RTC_BASE (default 30h). A write that touches this section commits only if it carries at least 8 bytes and every one of them falls inside the section.
- R11: An array write whose addresses all lie outside the protected window commits, including writes that start right below the window or right above its end. A write that crosses into the window is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_start | input | 1 | Pulse: a write transaction to this device begins |
| txn_space | input | 1 | Target space, sampled with `txn_start` (0 array, 1 register bank) |
| byte_ack | input | 1 | Pulse: a full data byte was received and acknowledged |
| byte_addr | input | AW | Address of the byte reported by `byte_ack` |
| byte_data | input | 8 | Value of the byte reported by `byte_ack` |
| mid_byte | input | 1 | Level: bits of an unfinished data byte have been received |
| stop_evt | input | 1 | Pulse: a stop condition was seen on the bus |
| prot_base | input | AW | First address of the protected array window |
| prot_size | input | AW | Size of the protected window (0 = none) |
| commit_pulse | output | 1 | One-cycle strobe that starts a storage commit |
| commit_space | output | 1 | Space being committed, valid with `commit_pulse` |
| busy | output | 1 | Commit window in progress; the front end stays off the bus |
| reg_unlocked | output | 1 | Register-bank writes are enabled |

## Verification
The stop is sampled at one rising edge. `commit_pulse`, `commit_space` and the first cycle of `busy` are all registered at that edge, and so is the new unlock state. Each result is therefore due in the cycle that follows the stop. The bench drives stimulus on falling edges and reads results on the falling edge right after the stop was captured. To check the busy length, it counts the falling edges on which `busy` is high, and it must see exactly COMMIT_CYCLES of them. For each ignored or discarded write, the bench reads `commit_pulse`, `busy` and `reg_unlocked` at that same falling edge, before any further stimulus arrives.

// File: rtl/nvc_pkg.sv
package nvc_pkg;

  typedef enum logic [1:0] {
    UL_LOCKED = 2'd0,
    UL_HALF   = 2'd1,
    UL_OPEN   = 2'd2
  } unlock_e;

  // Address a falls in [base, base+size); size 0 gives an empty window.
  function automatic logic in_window(input int unsigned a,
                                     input int unsigned base,
                                     input int unsigned size);
    return (a >= base) && ((a - base) < size);
  endfunction

endpackage

// File: rtl/nvc_txn_tracker.sv
module nvc_txn_tracker #(
  parameter int AW          = 16,
  parameter int CNTW        = 4,
  parameter int STATUS_ADDR = 'h3F,
  parameter int RTC_BASE    = 'h30,
  parameter int RTC_LEN     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          txn_start,
  input  logic          txn_space,
  input  logic          byte_ack,
  input  logic [AW-1:0] byte_addr,
  input  logic [7:0]    byte_data,
  input  logic          mid_byte,
  input  logic          stop_evt,
  input  logic [AW-1:0] prot_base,
  input  logic [AW-1:0] prot_size,
  output logic          clean_stop,
  output logic          reg_space,
  output logic          array_ok,
  output logic          prot_hit,
  output logic          rtc_ok,
  output logic          status_op,
  output logic          status_bad,
  output logic [7:0]    status_val
);
  import nvc_pkg::*;

  localparam logic [CNTW-1:0] CMAX = {CNTW{1'b1}};

  logic            active_q, space_q, prot_q, st_q, rtc_q, plain_q;
  logic [CNTW-1:0] cnt_q;
  logic [7:0]      last_q;
  logic            b_status, b_rtc, b_prot;

  assign b_status = (byte_addr == AW'(STATUS_ADDR));
  assign b_rtc    = in_window(32'(byte_addr), RTC_BASE, RTC_LEN);
  assign b_prot   = in_window(32'(byte_addr), 32'(prot_base), 32'(prot_size));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      space_q  <= 1'b0;
      prot_q   <= 1'b0;
      st_q     <= 1'b0;
      rtc_q    <= 1'b0;
      plain_q  <= 1'b0;
      cnt_q    <= '0;
      last_q   <= '0;
    end else if (en) begin
      if (stop_evt) begin
        active_q <= 1'b0;
      end else if (txn_start) begin
        active_q <= 1'b1;
        space_q  <= txn_space;
        cnt_q    <= '0;
        prot_q   <= 1'b0;
        st_q     <= 1'b0;
        rtc_q    <= 1'b0;
        plain_q  <= 1'b0;
      end else if (byte_ack && active_q) begin
        if (cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
        last_q <= byte_data;
        if (space_q) begin
          if (b_status)   st_q    <= 1'b1;
          else if (b_rtc) rtc_q   <= 1'b1;
          else            plain_q <= 1'b1;
        end else if (b_prot) begin
          prot_q <= 1'b1;
        end
      end
    end
  end

  assign clean_stop = en && stop_evt && active_q && (cnt_q != '0) && !mid_byte;
  assign reg_space  = space_q;
  assign array_ok   = !space_q && !prot_q;
  assign prot_hit   = !space_q && prot_q;
  assign rtc_ok     = !st_q && (!rtc_q || (!plain_q && (cnt_q >= CNTW'(RTC_LEN))));
  assign status_op  = space_q && st_q && (cnt_q == CNTW'(1));
  assign status_bad = space_q && st_q && (cnt_q != CNTW'(1));
  assign status_val = last_q;

endmodule

// File: rtl/nvc_unlock_fsm.sv
module nvc_unlock_fsm #(
  parameter logic [7:0] KEY1 = 8'h02,
  parameter logic [7:0] KEY2 = 8'h06
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clean_stop,
  input  logic       status_op,
  input  logic       status_bad,
  input  logic [7:0] status_val,
  output logic       unlocked
);
  import nvc_pkg::*;

  unlock_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (clean_stop) begin
      if (status_op) begin
        if (status_val == KEY1)                         st_d = UL_HALF;
        else if (status_val == KEY2 && st_q == UL_HALF) st_d = UL_OPEN;
        else                                            st_d = UL_LOCKED;
      end else if (status_bad || st_q == UL_HALF) begin
        st_d = UL_LOCKED;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= UL_LOCKED;
    else        st_q <= st_d;
  end

  assign unlocked = (st_q == UL_OPEN);

endmodule

// File: rtl/nvc_busy_timer.sv
module nvc_busy_timer #(
  parameter int CYCLES = 120000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic pulse,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          pulse_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= start && (cnt_q == '0);
      if (start && cnt_q == '0) cnt_q <= CW'(CYCLES);
      else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
    end
  end

  assign pulse = pulse_q;
  assign busy  = (cnt_q != '0);

endmodule

// File: rtl/nv_commit_ctrl.sv
module nv_commit_ctrl #(
  parameter int AW            = 16,
  parameter int COMMIT_CYCLES = 120000,
  parameter int STATUS_ADDR   = 'h3F,
  parameter int RTC_BASE      = 'h30,
  parameter int RTC_LEN       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          txn_start,
  input  logic          txn_space,
  input  logic          byte_ack,
  input  logic [AW-1:0] byte_addr,
  input  logic [7:0]    byte_data,
  input  logic          mid_byte,
  input  logic          stop_evt,
  input  logic [AW-1:0] prot_base,
  input  logic [AW-1:0] prot_size,
  output logic          commit_pulse,
  output logic          commit_space,
  output logic          busy,
  output logic          reg_unlocked
);
  localparam int CNTW = $clog2(RTC_LEN) + 1;

  // Named internal events, brought out for the checker.
  logic       ev_clean_stop, ev_commit_req, ev_status_bad, ev_prot_discard;
  logic       reg_space, array_ok, prot_hit, rtc_ok, status_op;
  logic [7:0] status_val;
  logic       space_q;

  nvc_txn_tracker #(
    .AW(AW), .CNTW(CNTW), .STATUS_ADDR(STATUS_ADDR),
    .RTC_BASE(RTC_BASE), .RTC_LEN(RTC_LEN)
  ) u_trk (
    .clk(clk), .rst_n(rst_n), .en(!busy),
    .txn_start(txn_start), .txn_space(txn_space),
    .byte_ack(byte_ack), .byte_addr(byte_addr), .byte_data(byte_data),
    .mid_byte(mid_byte), .stop_evt(stop_evt),
    .prot_base(prot_base), .prot_size(prot_size),
    .clean_stop(ev_clean_stop), .reg_space(reg_space),
    .array_ok(array_ok), .prot_hit(prot_hit), .rtc_ok(rtc_ok),
    .status_op(status_op), .status_bad(ev_status_bad),
    .status_val(status_val)
  );

  nvc_unlock_fsm u_unl (
    .clk(clk), .rst_n(rst_n), .clean_stop(ev_clean_stop),
    .status_op(status_op), .status_bad(ev_status_bad),
    .status_val(status_val), .unlocked(reg_unlocked)
  );

  assign ev_commit_req   = ev_clean_stop &&
                           (reg_space ? (reg_unlocked && rtc_ok) : array_ok);
  assign ev_prot_discard = ev_clean_stop && prot_hit;

  nvc_busy_timer #(.CYCLES(COMMIT_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(ev_commit_req),
    .pulse(commit_pulse), .busy(busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)             space_q <= 1'b0;
    else if (ev_commit_req) space_q <= reg_space;
  end

  assign commit_space = space_q;

endmodule

// File: rtl/nvc_checker.sv
module nvc_checker (
  input logic clk,
  input logic rst_n,
  input logic stop_evt,
  input logic mid_byte,
  input logic busy,
  input logic commit_pulse,
  input logic reg_unlocked,
  input logic ev_commit_req,
  input logic ev_status_bad,
  input logic ev_prot_discard
);

  a_r2_commit_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    ev_commit_req |=> commit_pulse);

  a_r3_abort_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && mid_byte) |=> !commit_pulse);

  a_r4_protected_discard: assert property (@(posedge clk) disable iff (!rst_n)
    ev_prot_discard |=> (!commit_pulse && !busy));

  a_r5_pulse_opens_window: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |-> (busy && !$past(busy)));

  a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |=> !commit_pulse);

  a_r6_unlock_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(reg_unlocked));

  a_r6_no_req_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ev_commit_req);

  a_r8_bad_status_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_status_bad && !busy && stop_evt) |=> !reg_unlocked);

endmodule

bind nv_commit_ctrl nvc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .stop_evt(stop_evt), .mid_byte(mid_byte),
  .busy(busy), .commit_pulse(commit_pulse), .reg_unlocked(reg_unlocked),
  .ev_commit_req(ev_commit_req), .ev_status_bad(ev_status_bad),
  .ev_prot_discard(ev_prot_discard)
);

// File: tb/tb_nv_commit_ctrl.sv
module tb_nv_commit_ctrl;
  localparam int AW   = 16;
  localparam int NCYC = 20;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, txn_start, txn_space, byte_ack, mid_byte, stop_evt;
  logic [AW-1:0] byte_addr, prot_base, prot_size;
  logic [7:0]    byte_data;
  logic          commit_pulse, commit_space, busy, reg_unlocked;

  nv_commit_ctrl #(.AW(AW), .COMMIT_CYCLES(NCYC)) dut (
    .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_space(txn_space),
    .byte_ack(byte_ack), .byte_addr(byte_addr), .byte_data(byte_data),
    .mid_byte(mid_byte), .stop_evt(stop_evt),
    .prot_base(prot_base), .prot_size(prot_size),
    .commit_pulse(commit_pulse), .commit_space(commit_space),
    .busy(busy), .reg_unlocked(reg_unlocked)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Entry: {space, addr[15:0], nbytes[3:0], data[7:0], mid, expect_commit}
  localparam int NV = 10;
  localparam logic [30:0] VEC [NV] = '{
    {1'b0, 16'h0010, 4'd1, 8'h55, 1'b0, 1'b1},
    {1'b0, 16'h0010, 4'd0, 8'h00, 1'b0, 1'b0},
    {1'b0, 16'h0020, 4'd3, 8'hA0, 1'b1, 1'b0},
    {1'b0, 16'h0100, 4'd1, 8'h11, 1'b0, 1'b0},
    {1'b0, 16'h00FF, 4'd1, 8'h22, 1'b0, 1'b1},
    {1'b0, 16'h00FF, 4'd2, 8'h33, 1'b0, 1'b0},
    {1'b0, 16'h0120, 4'd4, 8'h44, 1'b0, 1'b1},
    {1'b0, 16'h011F, 4'd1, 8'h66, 1'b0, 1'b0},
    {1'b1, 16'h0005, 4'd1, 8'h77, 1'b0, 1'b0},
    {1'b1, 16'h0030, 4'd8, 8'h88, 1'b0, 1'b0}
  };

  function automatic string vreq(input int k);
    case (k)
      0:       return "R2";
      1, 2:    return "R3";
      3, 7:    return "R4";
      4, 5, 6: return "R11";
      default: return "R9";
    endcase
  endfunction

  task automatic drive_write(input logic sp, input logic [15:0] a0, input int n,
                             input logic [7:0] d0, input logic mid);
    @(negedge clk);
    txn_start = 1'b1;
    txn_space = sp;
    @(negedge clk);
    txn_start = 1'b0;
    for (int i = 0; i < n; i++) begin
      byte_ack  = 1'b1;
      byte_addr = a0 + 16'(i);
      byte_data = d0 + 8'(i);
      @(negedge clk);
      byte_ack = 1'b0;
      @(negedge clk);
    end
    mid_byte = mid;
    stop_evt = 1'b1;
    @(negedge clk);
    stop_evt = 1'b0;
    mid_byte = 1'b0;
  endtask

  task automatic run_write(input logic sp, input logic [15:0] a0, input int n,
                           input logic [7:0] d0, input logic mid, input logic expc,
                           input string req);
    int cnt;
    drive_write(sp, a0, n, d0, mid);
    chk({req, " commit_pulse"}, commit_pulse, expc);
    chk({req, " busy"}, busy, expc);
    if (expc) begin
      chk("R2 commit_space", commit_space, sp);
      cnt = 0;
      while (busy && cnt < NCYC + 5) begin
        cnt++;
        @(negedge clk);
      end
      chk("R5 busy length", cnt, NCYC);
    end else begin
      @(negedge clk);
      chk({req, " no late commit"}, commit_pulse, 1'b0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; txn_start = 1'b0; txn_space = 1'b0; byte_ack = 1'b0;
    mid_byte = 1'b0; stop_evt = 1'b0; byte_addr = '0; byte_data = '0;
    prot_base = 16'h0100; prot_size = 16'h0020;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", busy, 1'b0);
    chk("R1 commit_pulse", commit_pulse, 1'b0);
    chk("R1 reg_unlocked", reg_unlocked, 1'b0);

    for (int k = 0; k < NV; k++) begin
      logic [30:0] v;
      v = VEC[k];
      run_write(v[30], v[29:14], int'(v[13:10]), v[9:2], v[1], v[0], vreq(k));
    end
    chk("R9 still locked", reg_unlocked, 1'b0);

    // R7 unlock with an aborted status write in between (R3: no effect)
    run_write(1'b1, 16'h003F, 1, 8'h02, 1'b0, 1'b0, "R7");
    chk("R7 half step locked", reg_unlocked, 1'b0);
    run_write(1'b1, 16'h003F, 1, 8'h06, 1'b1, 1'b0, "R3");
    chk("R3 abort keeps state", reg_unlocked, 1'b0);
    run_write(1'b1, 16'h003F, 1, 8'h06, 1'b0, 1'b0, "R7");
    chk("R7 unlocked", reg_unlocked, 1'b1);

    run_write(1'b1, 16'h0005, 1, 8'h5A, 1'b0, 1'b1, "R9");
    run_write(1'b1, 16'h0030, 8, 8'h10, 1'b0, 1'b1, "R10");
    run_write(1'b1, 16'h0030, 7, 8'h10, 1'b0, 1'b0, "R10");
    run_write(1'b1, 16'h0032, 8, 8'h10, 1'b0, 1'b0, "R10");
    chk("R9 unlock held", reg_unlocked, 1'b1);

    // R6: writes during the busy window are ignored
    drive_write(1'b0, 16'h0010, 1, 8'hC3, 1'b0);
    chk("R6 first commit", commit_pulse, 1'b1);
    drive_write(1'b1, 16'h003F, 1, 8'h11, 1'b0);
    chk("R6 status ignored", commit_pulse, 1'b0);
    drive_write(1'b0, 16'h0040, 1, 8'h12, 1'b0);
    chk("R6 array ignored", commit_pulse, 1'b0);
    while (busy) @(negedge clk);
    @(negedge clk);
    chk("R6 no late commit", commit_pulse, 1'b0);
    chk("R6 unlock unchanged", reg_unlocked, 1'b1);

    // R8: wrong status value locks; interrupted sequence stays locked
    run_write(1'b1, 16'h003F, 1, 8'h11, 1'b0, 1'b0, "R8");
    chk("R8 locked by bad value", reg_unlocked, 1'b0);
    run_write(1'b1, 16'h003F, 1, 8'h02, 1'b0, 1'b0, "R8");
    run_write(1'b0, 16'h0200, 1, 8'h01, 1'b0, 1'b1, "R8");
    run_write(1'b1, 16'h003F, 1, 8'h06, 1'b0, 1'b0, "R8");
    chk("R8 interrupted sequence", reg_unlocked, 1'b0);
    run_write(1'b1, 16'h003F, 1, 8'h02, 1'b0, 1'b0, "R8");
    run_write(1'b1, 16'h003F, 1, 8'h06, 1'b0, 1'b0, "R8");
    chk("R8 reunlocked", reg_unlocked, 1'b1);
    run_write(1'b1, 16'h003E, 2, 8'h06, 1'b0, 1'b0, "R8");
    chk("R8 multibyte status locks", reg_unlocked, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule